// File: doc/BRIEF.md
# Holdover History Tracker

This block holds the frequency history that a clock synchronizer falls back on when it loses its reference, and it tells the downstream controller whether that history can be trusted. A long-term averaged frequency word arrives with an update strobe, and each accepted strobe copies it into a learned history register. Three kinds of reference trouble freeze the learned history at its last value: a switch to another reference, a loss of signal or loss of lock, and entry into freerun or holdover. A flush-register write also freezes it. Only a flush write carrying 1 erases the history and withdraws availability.

The availability flag tells the controller which way to go when no valid reference is selected in automatic selection. A flag of 1 means the controller enters holdover with the history. A flag of 0 means it enters freerun. A mode select can substitute a user-programmed history word for the learned one. While that mode is selected the flag reads 1, and the learned history keeps running underneath, unharmed.

A frozen history accepts updates again only after the reference has been good for a whole update period. That period is measured from one strobe taken with a good reference to the next strobe, with the reference good throughout. The tracker leaves reset frozen and must qualify in the same way before it learns anything.

Top module: `hold_hist_track`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the history output is 0 and the flag is 0 in learned mode.
- R2: In learned mode, while the tracker is not frozen, a strobe with no event and no flush write in the same cycle loads the averaged word into the history. The new value and a flag of 1 appear on the outputs one cycle after the strobe.
- R3: A pulse on the reference-switch, signal/lock-loss or freerun/holdover-entry input freezes the history. Later strobes leave the history unchanged, and the flag keeps its value.
- R4: A flush write with a data bit of 0 freezes the history and leaves the flag unchanged.
- R5: A flush write with a data bit of 1 sets the learned history to 0 and the flag to 0 on the next cycle, and it freezes the tracker. It takes priority over events and strobes in the same cycle.
- R6: An event or flush write in the same cycle as a strobe wins: that strobe is not loaded.
- R7: While frozen, a strobe with the reference-good input at 1 arms the tracker and is not loaded. The next strobe is loaded, and the tracker unfreezes, if the reference-good input stayed at 1 through every cycle from the arming strobe to this one. A 0 on reference-good, or any event or flush write, disarms the tracker.
- R8: With the mode select at 1 (user mode), from the next cycle on the flag is 1 and the history output equals the user word. Returning the mode select to 0 shows the learned history again, including every update taken while in user mode.
- R9: After reset the tracker is frozen and unarmed, so the first loaded strobe is the second good strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_word | input | W | Long-term averaged frequency word, signed |
| avg_vld | input | 1 | Update strobe for avg_word |
| ev_refsw | input | 1 | Reference switch event pulse |
| ev_loss | input | 1 | Loss of signal or loss of lock pulse |
| ev_nofollow | input | 1 | Entry into freerun or holdover pulse |
| flush_we | input | 1 | Flush register write strobe |
| flush_val | input | 1 | Flush data: 1 erases history, 0 only freezes |
| ref_good | input | 1 | Selected reference locked and valid |
| use_user | input | 1 | Mode select: 1 = user history, 0 = learned |
| user_word | input | W | User-programmed history word, signed |
| hist_out | output | W | Active history word, signed |
| avail | output | 1 | History availability flag |

## Verification
The hardest state to reach is the moment a frozen tracker resumes. That needs two strobes taken with a good reference, with no reference dropout, event or flush write between them. Random stimulus rarely produces that window, so the bench keeps reference-good mostly high, sends strobes sparsely and events rarely. Directed sequences also build the window on purpose and then break it with a one-cycle reference dropout.

// File: rtl/hold_hist_track.sv
module hold_hist_track #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] avg_word,
  input  logic                avg_vld,
  input  logic                ev_refsw,
  input  logic                ev_loss,
  input  logic                ev_nofollow,
  input  logic                flush_we,
  input  logic                flush_val,
  input  logic                ref_good,
  input  logic                use_user,
  input  logic signed [W-1:0] user_word,
  output logic signed [W-1:0] hist_out,
  output logic                avail
);

  logic signed [W-1:0] lrn_hist;
  logic lrn_avail, frozen, arm, mode_q;

  wire erase  = flush_we & flush_val;
  wire freeze = ev_refsw | ev_loss | ev_nofollow | flush_we;
  wire resume = frozen & arm & avg_vld & ref_good;
  wire load   = avg_vld & ~freeze & (~frozen | resume);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrn_hist  <= '0;
      lrn_avail <= 1'b0;
      frozen    <= 1'b1;
      arm       <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      mode_q <= use_user;
      if (erase) begin
        lrn_hist  <= '0;
        lrn_avail <= 1'b0;
        frozen    <= 1'b1;
        arm       <= 1'b0;
      end else if (freeze) begin
        frozen <= 1'b1;
        arm    <= 1'b0;
      end else if (frozen && !ref_good) begin
        arm <= 1'b0;
      end else if (load) begin
        lrn_hist  <= avg_word;
        lrn_avail <= 1'b1;
        frozen    <= 1'b0;
        arm       <= 1'b0;
      end else if (frozen && avg_vld) begin
        arm <= 1'b1;
      end
    end
  end

  assign hist_out = mode_q ? user_word : lrn_hist;
  assign avail    = mode_q | lrn_avail;

endmodule

// File: rtl/hold_hist_track_chk.sv
module hold_hist_track_chk #(
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic signed [W-1:0] avg_word,
  input logic                avg_vld,
  input logic                ev_refsw,
  input logic                ev_loss,
  input logic                ev_nofollow,
  input logic                flush_we,
  input logic                flush_val,
  input logic                ref_good,
  input logic                use_user,
  input logic signed [W-1:0] user_word,
  input logic signed [W-1:0] hist_out,
  input logic                avail,
  input logic signed [W-1:0] lrn_hist,
  input logic                lrn_avail,
  input logic                frozen,
  input logic                arm
);

  wire any_ev = ev_refsw | ev_loss | ev_nofollow;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && avg_vld && !any_ev && !flush_we) |=>
      (lrn_hist == $past(avg_word) && lrn_avail && !frozen));

  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ev && !flush_we) |=> (frozen && lrn_avail == $past(lrn_avail)
      && lrn_hist == $past(lrn_hist)));

  a_r4_soft_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_we && !flush_val) |=> (frozen && lrn_avail == $past(lrn_avail)));

  a_r5_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_we && flush_val) |=> (lrn_hist == '0 && !lrn_avail && frozen && !arm));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm && !flush_we) |=> (lrn_hist == $past(lrn_hist)));

  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ref_good) |=> !arm);

  a_r8_user: assert property (@(posedge clk) disable iff (!rst_n)
    use_user |=> (avail && hist_out == user_word));

endmodule

bind hold_hist_track hold_hist_track_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .avg_word(avg_word), .avg_vld(avg_vld),
  .ev_refsw(ev_refsw), .ev_loss(ev_loss), .ev_nofollow(ev_nofollow),
  .flush_we(flush_we), .flush_val(flush_val), .ref_good(ref_good),
  .use_user(use_user), .user_word(user_word), .hist_out(hist_out),
  .avail(avail), .lrn_hist(lrn_hist), .lrn_avail(lrn_avail),
  .frozen(frozen), .arm(arm)
);

// File: tb/sim_hold_hist_track.sv
`timescale 1ns/1ps
module sim_hold_hist_track;
  localparam int W = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [W-1:0] avg_word = '0, user_word = '0;
  logic avg_vld = 0, ev_refsw = 0, ev_loss = 0, ev_nofollow = 0;
  logic flush_we = 0, flush_val = 0, ref_good = 0, use_user = 0;
  logic signed [W-1:0] hist_out;
  logic avail;

  hold_hist_track #(.W(W)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic signed [W-1:0] m_hist = '0;
  logic m_avail = 0, m_frozen = 1, m_arm = 0, m_mode = 0;

  function automatic logic signed [W-1:0] exp_hist();
    return m_mode ? user_word : m_hist;
  endfunction
  function automatic logic exp_avail();
    return m_mode | m_avail;
  endfunction

  task automatic model_edge();
    logic fr, ld;
    if (!rst_n) begin
      m_hist = '0; m_avail = 0; m_frozen = 1; m_arm = 0; m_mode = 0;
      return;
    end
    m_mode = use_user;
    fr = ev_refsw | ev_loss | ev_nofollow | flush_we;
    if (flush_we && flush_val) begin
      m_hist = '0; m_avail = 0; m_frozen = 1; m_arm = 0;
    end else if (fr) begin
      m_frozen = 1; m_arm = 0;
    end else if (m_frozen && !ref_good) begin
      m_arm = 0;
    end else if (avg_vld) begin
      ld = !m_frozen || m_arm;
      if (ld) begin
        m_hist = avg_word; m_avail = 1; m_frozen = 0; m_arm = 0;
      end else m_arm = 1;
    end
  endtask

  task automatic chk(string tag);
    checks++;
    if (hist_out !== exp_hist() || avail !== exp_avail()) begin
      errors++;
      $display("FAIL %s: hist=%0d avail=%0b expected hist=%0d avail=%0b",
               tag, hist_out, avail, exp_hist(), exp_avail());
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    #2;
    chk(tag);
    avg_vld = 0; ev_refsw = 0; ev_loss = 0; ev_nofollow = 0; flush_we = 0; flush_val = 0;
  endtask

  task automatic strobe(logic signed [W-1:0] v, string tag);
    avg_word = v; avg_vld = 1; tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    tick("R1 in reset");
    tick("R1 in reset");
    rst_n = 1;
    tick("R1 after release");
    ref_good = 1;
    strobe(24'sd1000, "R9 first good strobe only arms");
    tick("R9 idle");
    strobe(24'sd1000, "R7 second good strobe loads");
    strobe(-24'sd77, "R2 update negative");
    strobe(24'sd4242, "R2 update positive");
    ev_refsw = 1; tick("R3 ref switch");
    strobe(24'sd5, "R3 frozen after ref switch");
    tick("R3 idle");
    ref_good = 0; tick("R7 dropout");
    ref_good = 1;
    strobe(24'sd6, "R7 rearm");
    ref_good = 0; tick("R7 dropout between strobes");
    ref_good = 1;
    strobe(24'sd7, "R7 dropout disarmed");
    strobe(24'sd8, "R7 resume");
    ev_loss = 1; tick("R3 loss");
    strobe(24'sd9, "R3 frozen after loss");
    strobe(24'sd10, "R7 resume after loss");
    ev_nofollow = 1; tick("R3 mode entry");
    strobe(24'sd11, "R3 frozen after mode entry");
    strobe(24'sd12, "R7 resume after mode entry");
    flush_we = 1; flush_val = 0; tick("R4 soft flush");
    strobe(24'sd13, "R4 frozen flag kept");
    strobe(24'sd14, "R7 resume after soft flush");
    ev_loss = 1; strobe(24'sd15, "R6 event beats strobe");
    strobe(24'sd16, "R6 arm");
    strobe(24'sd17, "R6 resume");
    flush_we = 1; flush_val = 1; ev_refsw = 1;
    strobe(24'sd18, "R5 erase beats all");
    strobe(24'sd19, "R5 arm after erase");
    user_word = -24'sd321; use_user = 1;
    tick("R8 mode switch edge");
    tick("R8 user mode");
    strobe(24'sd20, "R8 learned runs under user mode");
    user_word = 24'sd99; tick("R8 user word change");
    use_user = 0; tick("R8 back to learned");
    tick("R8 learned kept");
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      avg_word = $signed(24'($urandom));
      avg_vld = (r % 3) == 0;
      ref_good = $urandom_range(0, 19) != 0;
      ev_refsw = $urandom_range(0, 59) == 0;
      ev_loss = $urandom_range(0, 59) == 0;
      ev_nofollow = $urandom_range(0, 59) == 0;
      flush_we = $urandom_range(0, 79) == 0;
      flush_val = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 49) == 0) use_user = ~use_user;
      if ($urandom_range(0, 9) == 0) user_word = $signed(24'($urandom));
      tick("R2 R3 R5 R7 R8 random");
    end
    rst_n = 0; tick("R1 second reset");
    finish_run();
  end

  initial void'($urandom(32'd1234));
endmodule